// File: doc/BRIEF.md
# Card-controller interrupt router with DMA steering

This block collects the event flags raised by the other parts of a memory-card host controller and turns them into a single processor interrupt line. A 13-bit request register holds one flag per event source. Producers raise flags with per-bit set strobes, and consumers lower them with per-bit clear strobes. A 13-bit mask register, loaded from a 32-bit write bus, selects which flags may not reach the processor.

When the DMA enable input is high, the receive-FIFO and transmit-FIFO service flags (bits 5 and 6) are taken away from the processor interrupt. They drive two dedicated DMA request lines instead, so that a DMA engine can move FIFO data without processor involvement. When DMA is off, both DMA lines stay low and the two flags behave like any other source.

The request and mask registers are brought out as ports so that the owning register file can read them back. All three request outputs come from registers.

Top module: `mmc_irq_router`

## Requirements
- R1: After synchronous reset, the request register, the mask register, the processor interrupt and both DMA request outputs are all 0.
- R2: A 1 on `set_i[b]` makes `req_o[b]` read 1 after the next rising clock edge. The flag bits are: 0 data done, 1 program done, 2 end command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: A 1 on `clr_i[b]` with `set_i[b]` low makes `req_o[b]` read 0 after the next rising edge. Bits that are neither set nor cleared keep their value.
- R4: When `set_i[b]` and `clr_i[b]` are both 1 in the same cycle, the set wins and `req_o[b]` reads 1.
- R5: A write with `mask_we` high loads `mask_wdata[12:0]` into `mask_o` at the next edge. Bits 31..13 of the write data are ignored.
- R6: With DMA off, `cpu_irq` is 1 exactly when some bit is 1 in `req_o` and 0 in `mask_o`. The output register reflects the request and mask values one edge after they appear on `req_o` and `mask_o`, which is two edges after the strobe or write.
- R7: With DMA on, request bits 5 and 6 never contribute to `cpu_irq`, whatever the mask holds.
- R8: With DMA on, `rx_dma_req` equals request bit 5 and `tx_dma_req` equals request bit 6, regardless of the mask.
- R9: With DMA off, `rx_dma_req` and `tx_dma_req` are 0. The `dma_en` input takes effect on the outputs two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 13 | Per-flag set strobes |
| clr_i | input | 13 | Per-flag clear strobes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 32 | Mask write data; only bits 12..0 are kept |
| dma_en | input | 1 | Steers FIFO flags to the DMA lines |
| req_o | output | 13 | Current request register |
| mask_o | output | 13 | Current mask register |
| cpu_irq | output | 1 | Processor interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Strobes and mask writes show up on `req_o` and `mask_o` one rising edge after they are applied. `cpu_irq`, `rx_dma_req` and `tx_dma_req` follow one edge later, as does any change of `dma_en`. The bench keeps a model of the register state and, at every edge, captures the output values that the model predicts from the state before that edge. It then compares all five outputs at the following falling edge, so every check lands on the cycle in which each result is due.

// File: rtl/mir_pkg.sv
package mir_pkg;
  localparam int unsigned FLAG_COUNT = 13;
  localparam int unsigned BUS_WIDTH  = 32;
  localparam int unsigned RX_FLAG    = 5;
  localparam int unsigned TX_FLAG    = 6;

  typedef struct packed {
    logic irq;
    logic rx;
    logic tx;
  } route_out_t;
endpackage

// File: rtl/mir_req_reg.sv
module mir_req_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_q
);
  for (genvar b = 0; b < N; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[b] <= 1'b0;
      end else if (set_i[b]) begin
        req_q[b] <= 1'b1;        // set has priority over clear
      end else if (clr_i[b]) begin
        req_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mir_mask_reg.sv
module mir_mask_reg #(
  parameter int unsigned N  = 13,
  parameter int unsigned WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [WW-1:0] wdata,
  output logic [N-1:0]  mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (we) begin
      mask_q <= wdata[N-1:0];
    end
  end
endmodule

// File: rtl/mir_out_stage.sv
module mir_out_stage
  import mir_pkg::*;
#(
  parameter int unsigned N   = 13,
  parameter int unsigned RXB = 5,
  parameter int unsigned TXB = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  input  logic         dma_en,
  output route_out_t   route_q
);
  localparam logic [N-1:0] STEER_BITS = (N'(1) << RXB) | (N'(1) << TXB);

  logic         dma_q;
  logic [N-1:0] eff_mask;
  route_out_t   route_d;

  always_comb begin
    eff_mask    = mask | (dma_q ? STEER_BITS : '0);
    route_d.irq = |(req & ~eff_mask);
    route_d.rx  = dma_q & req[RXB];
    route_d.tx  = dma_q & req[TXB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_q   <= 1'b0;
      route_q <= '0;
    end else begin
      dma_q   <= dma_en;
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
  import mir_pkg::*;
#(
  parameter int unsigned N   = FLAG_COUNT,
  parameter int unsigned WW  = BUS_WIDTH,
  parameter int unsigned RXB = RX_FLAG,
  parameter int unsigned TXB = TX_FLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          mask_we,
  input  logic [WW-1:0] mask_wdata,
  input  logic          dma_en,
  output logic [N-1:0]  req_o,
  output logic [N-1:0]  mask_o,
  output logic          cpu_irq,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);
  route_out_t route_q;

  mir_req_reg #(.N(N)) u_req (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_i),
    .clr_i (clr_i),
    .req_q (req_o)
  );

  mir_mask_reg #(.N(N), .WW(WW)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we     (mask_we),
    .wdata  (mask_wdata),
    .mask_q (mask_o)
  );

  mir_out_stage #(.N(N), .RXB(RXB), .TXB(TXB)) u_out (
    .clk     (clk),
    .rst     (rst),
    .req     (req_o),
    .mask    (mask_o),
    .dma_en  (dma_en),
    .route_q (route_q)
  );

  assign cpu_irq    = route_q.irq;
  assign rx_dma_req = route_q.rx;
  assign tx_dma_req = route_q.tx;
endmodule

// File: rtl/mir_checker.sv
module mir_checker #(
  parameter int unsigned N   = 13,
  parameter int unsigned WW  = 32,
  parameter int unsigned RXB = 5,
  parameter int unsigned TXB = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  set_i,
  input logic [N-1:0]  clr_i,
  input logic          mask_we,
  input logic [WW-1:0] mask_wdata,
  input logic          dma_en,
  input logic [N-1:0]  req_o,
  input logic [N-1:0]  mask_o,
  input logic          cpu_irq,
  input logic          rx_dma_req,
  input logic          tx_dma_req
);
  localparam logic [N-1:0] FIFO_BITS = (N'(1) << RXB) | (N'(1) << TXB);

  // R2
  set_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((req_o & $past(set_i)) == $past(set_i)));

  // R3
  clr_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((req_o & $past(clr_i & ~set_i)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & clr_i)) |=> ((req_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_o == $past(mask_wdata[N-1:0])));

  // R6 R7
  irq_route_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (|($past(req_o) & ~($past(mask_o) | ($past(dma_en, 2) ? FIFO_BITS : '0)))));

  // R8
  dma_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dma_en, 2) |-> (rx_dma_req == $past(req_o[RXB]) && tx_dma_req == $past(req_o[TXB])));

  // R9
  dma_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dma_en, 2) |-> (!rx_dma_req && !tx_dma_req));
endmodule

bind mmc_irq_router mir_checker #(.N(N), .WW(WW), .RXB(RXB), .TXB(TXB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_i      (set_i),
  .clr_i      (clr_i),
  .mask_we    (mask_we),
  .mask_wdata (mask_wdata),
  .dma_en     (dma_en),
  .req_o      (req_o),
  .mask_o     (mask_o),
  .cpu_irq    (cpu_irq),
  .rx_dma_req (rx_dma_req),
  .tx_dma_req (tx_dma_req)
);

// File: tb/sim_mmc_irq_router.sv
module sim_mmc_irq_router;
  localparam int N = 13, WW = 32, RXB = 5, TXB = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  set_s = '0, clr_s = '0;
  logic          mask_we = 1'b0;
  logic [WW-1:0] mask_wdata = '0;
  logic          dma_en = 1'b0;
  logic [N-1:0]  req_o, mask_o;
  logic          cpu_irq, rx_dma_req, tx_dma_req;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_req = '0, m_mask = '0;
  logic m_dma = 1'b0, e_irq = 1'b0, e_rx = 1'b0, e_tx = 1'b0;

  always #4 clk = ~clk;

  mmc_irq_router u0 (
    .clk(clk), .rst(rst), .set_i(set_s), .clr_i(clr_s),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .dma_en(dma_en),
    .req_o(req_o), .mask_o(mask_o), .cpu_irq(cpu_irq),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  function automatic logic f_irq(logic [N-1:0] r, logic [N-1:0] m, logic d);
    logic [N-1:0] hide;
    hide = m;
    if (d) begin
      hide[RXB] = 1'b1;
      hide[TXB] = 1'b1;
    end
    return |(r & ~hide);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " req_o"},  32'(req_o),  32'(m_req));
    check({tag, " mask_o"}, 32'(mask_o), 32'(m_mask));
    check({tag, " cpu_irq"}, 32'(cpu_irq), 32'(e_irq));
    check({tag, " rx_dma_req"}, 32'(rx_dma_req), 32'(e_rx));
    check({tag, " tx_dma_req"}, 32'(tx_dma_req), 32'(e_tx));
  endtask

  // Drive one cycle of stimulus at a falling edge, model the edge, check at the next falling edge.
  task automatic step(string tag, logic [N-1:0] s, logic [N-1:0] c,
                      logic we, logic [WW-1:0] wd, logic d);
    logic n_irq, n_rx, n_tx;
    n_irq = f_irq(m_req, m_mask, m_dma);
    n_rx  = m_dma & m_req[RXB];
    n_tx  = m_dma & m_req[TXB];
    set_s = s; clr_s = c; mask_we = we; mask_wdata = wd; dma_en = d;
    @(posedge clk);
    m_req = (m_req & ~c) | s;
    if (we) m_mask = wd[N-1:0];
    m_dma = d;
    e_irq = n_irq; e_rx = n_rx; e_tx = n_tx;
    @(negedge clk);
    set_s = '0; clr_s = '0; mask_we = 1'b0;
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R2 then R6: end-command flag raises the interrupt one edge later
    step("R2 set bit2", N'(1) << 2, '0, 1'b0, '0, 1'b0);
    step("R6 irq from bit2", '0, '0, 1'b0, '0, 1'b0);
    // R5: upper write bits dropped, bit2 masked
    step("R5 mask write", '0, '0, 1'b1, 32'hFFFF_0004, 1'b0);
    step("R6 masked bit2", '0, '0, 1'b0, '0, 1'b0);
    step("R3 clear bit2", '0, N'(1) << 2, 1'b0, '0, 1'b0);
    // R4: set and clear of bit0 together
    step("R4 set wins", N'(1), N'(1), 1'b0, '0, 1'b0);
    step("R6 irq from bit0", '0, N'(1), 1'b1, '0, 1'b0);
    // R7 R8: FIFO flags steered to DMA lines with mask clear
    step("R8 raise fifo flags", (N'(1) << RXB) | (N'(1) << TXB), '0, 1'b0, '0, 1'b1);
    step("R8 dma lines", '0, '0, 1'b0, '0, 1'b1);
    step("R7 irq hidden", '0, '0, 1'b0, '0, 1'b1);
    step("R8 clear rx only", '0, N'(1) << RXB, 1'b0, '0, 1'b1);
    step("R8 rx drops", '0, '0, 1'b0, '0, 1'b1);
    // R9: DMA off returns flags to the processor line
    step("R9 dma off", '0, '0, 1'b0, '0, 1'b0);
    step("R9 dma lines low", '0, '0, 1'b0, '0, 1'b0);
    step("R6 tx flag on irq", '0, '0, 1'b0, '0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] rs, rc;
      rs = N'($urandom) & N'($urandom) & N'($urandom);
      rc = N'($urandom) & N'($urandom);
      step("random R2 R3 R4 R5 R6 R7 R8 R9", rs, rc,
           ($urandom % 8) == 0, $urandom, ($urandom % 4) != 0 ? dma_en : ~dma_en);
    end
    finish_run();
  end
endmodule